// File: doc/BRIEF.md
# Dual Pump Clock Generator

This block produces two clock outputs at one fixed frequency for switching external DC-to-DC converters. The duty ratio of each output is set in sixteenths of a period. A prescaler divides the system clock into slots, and sixteen slots form one period. With the default divide of 12 and an 18.432 MHz system clock, one period is 192 clocks, which gives an output near 96 kHz. Both outputs share one timebase, so their rising edges line up at each period start.

Software writes one control register that holds a 4-bit duty field for each channel and reads the same value back. A global enable input parks the timebase and holds both outputs low, so the converters can be stopped in standby. A duty change takes effect only at a period boundary, which keeps each output pulse whole.

Top module: `pump_clkgen`

## Requirements
- R1: While reset is applied and just after it is released, both drive outputs are low and the readback value is zero.
- R2: A write pulse stores the write data in the control register. Channel 0 duty is bits 3:0 and channel 1 duty is bits 7:4. The stored value appears on the readback port from the next clock.
- R3: While enabled, an output period is exactly 16 slots of PRESCALE clocks each (192 clocks by default), and it repeats without gaps.
- R4: For a duty field N from 1 to 15, an output is high for the first N slots of each period and low for the other 16-N slots. It rises only at the start of a period.
- R5: A duty field of 0 holds its output low for the whole period; the channel is off.
- R6: Each channel follows its own duty field, whatever the other field holds.
- R7: A duty value written during a period does not change the period in progress. It is used from the next period start onward.
- R8: While the enable input is low, both outputs are low from the first clock edge after enable is sampled low.
- R9: Dropping enable resets the slot timebase. When enable returns, a full period starts at slot 0 on the first clock edge with enable high, wherever the previous period stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable; low holds both outputs low and parks the timebase |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | CHANNELS*DUTY_W | Duty fields to store, channel 0 in the low bits |
| rd_data | output | CHANNELS*DUTY_W | Readback of the control register |
| drive | output | CHANNELS | Pump clock outputs, one bit per channel |

## Verification
The outputs are compared cycle by cycle against expected waveforms built from duty pairs. The pairs 1/3, 0/15, 8/0 and 2/5 separate the slot count from channel crosstalk, and they cover the off and full-scale ends of the field. A write in the middle of a period shows whether the running period keeps its old duty. Enable is dropped both at a period boundary and at slot 8 of a period; the restart that follows shows whether the timebase goes back to slot 0 or resumes where it stopped.

// File: rtl/pump_pkg.sv
package pump_pkg;

    // Defaults: 18.432 MHz / 12 / 16 slots = 96 kHz
    localparam int DEF_CHANNELS = 2;
    localparam int DEF_DUTY_W   = 4;
    localparam int DEF_PRESCALE = 12;

    // Counter width for a divide-by-n prescaler (n >= 2)
    function automatic int presc_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pump_timebase.sv
module pump_timebase
    import pump_pkg::*;
#(
    parameter int PRESCALE = DEF_PRESCALE,
    parameter int SLOT_W   = DEF_DUTY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              wrap
);
    localparam int PRE_W = presc_width(PRESCALE);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  presc;
        logic [SLOT_W-1:0] slot;
    } tb_state_t;

    // Parked position: last clock of the last slot
    localparam tb_state_t PARKED = '{presc: PRE_LAST, slot: {SLOT_W{1'b1}}};

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.presc == PRE_LAST) && (&st_q.slot);
        if (!en) begin
            st_d = PARKED;
        end else if (st_q.presc == PRE_LAST) begin
            st_d.presc = '0;
            st_d.slot  = st_q.slot + 1'b1;
        end else begin
            st_d.presc = st_q.presc + 1'b1;
        end
        slot_nxt = st_d.slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PARKED;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pump_channel.sv
module pump_channel
    import pump_pkg::*;
#(
    parameter int DUTY_W = DEF_DUTY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic [DUTY_W-1:0] slot_nxt,
    input  logic [DUTY_W-1:0] duty_cfg,
    output logic              drive
);
    typedef struct packed {
        logic [DUTY_W-1:0] act;
        logic              drv;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // Shadow copy only follows the register at a period start
        if (load) st_d.act = duty_cfg;
        st_d.drv = en && (slot_nxt < st_d.act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive = st_q.drv;

endmodule

// File: rtl/pump_regs.sv
module pump_regs
    import pump_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int DUTY_W   = DEF_DUTY_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CHANNELS*DUTY_W-1:0] wr_data,
    output logic [CHANNELS*DUTY_W-1:0] duty_flat
);
    logic [CHANNELS*DUTY_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign duty_flat = cfg_q;

endmodule

// File: rtl/pump_clkgen.sv
module pump_clkgen
    import pump_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int DUTY_W   = DEF_DUTY_W,
    parameter int PRESCALE = DEF_PRESCALE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       wr_en,
    input  logic [CHANNELS*DUTY_W-1:0] wr_data,
    output logic [CHANNELS*DUTY_W-1:0] rd_data,
    output logic [CHANNELS-1:0]        drive
);
    logic [CHANNELS*DUTY_W-1:0] duty_flat;
    logic [DUTY_W-1:0]          slot_nxt;
    logic                       period_wrap;

    pump_regs #(.CHANNELS(CHANNELS), .DUTY_W(DUTY_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .duty_flat (duty_flat)
    );

    pump_timebase #(.PRESCALE(PRESCALE), .SLOT_W(DUTY_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .slot_nxt (slot_nxt),
        .wrap     (period_wrap)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        pump_channel #(.DUTY_W(DUTY_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .load     (period_wrap),
            .slot_nxt (slot_nxt),
            .duty_cfg (duty_flat[ch*DUTY_W +: DUTY_W]),
            .drive    (drive[ch])
        );
    end

    assign rd_data = duty_flat;

endmodule

// File: rtl/pump_clkgen_chk.sv
module pump_clkgen_chk #(
    parameter int CHANNELS = 2,
    parameter int DUTY_W   = 4,
    parameter int PRESCALE = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic                       wr_en,
    input logic [CHANNELS*DUTY_W-1:0] wr_data,
    input logic [CHANNELS*DUTY_W-1:0] rd_data,
    input logic [CHANNELS-1:0]        drive,
    input logic                       wrap
);
    localparam int PERIOD = (1 << DUTY_W) * PRESCALE;
    localparam int CNT_W  = $clog2(PERIOD) + 1;

    logic [CNT_W-1:0] since_q;
    logic             armed_q;

    // Clocks since the last period start, counted only while enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else if (!en) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else if (wrap) begin
            since_q <= '0;
            armed_q <= 1'b1;
        end else begin
            since_q <= since_q + 1'b1;
        end
    end

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    // R3
    period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap && armed_q) |-> since_q == CNT_W'(PERIOD - 1));

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> drive == '0);

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_rise
        // R4
        rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drive[ch]) |-> $past(wrap && en));
    end

endmodule

bind pump_clkgen pump_clkgen_chk #(
    .CHANNELS (CHANNELS),
    .DUTY_W   (DUTY_W),
    .PRESCALE (PRESCALE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .drive   (drive),
    .wrap    (period_wrap)
);

// File: tb/pump_clkgen_tb.sv
module pump_clkgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 12;
    localparam int PERIOD     = PRE * 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [1:0] drive;

    int checks = 0;
    int fails  = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pump_clkgen #(.CHANNELS(2), .DUTY_W(4), .PRESCALE(PRE)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .drive   (drive)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected waveform: high while slot index < duty
    task automatic push_period(input int n0, input int n1, input int len, input string tag);
        for (int j = 0; j < len; j++) begin
            exp_q.push_back({logic'((j / PRE) < n1), logic'((j / PRE) < n0)});
            tag_q.push_back(tag);
        end
    endtask

    task automatic push_zero(input int len, input string tag);
        for (int j = 0; j < len; j++) begin
            exp_q.push_back(2'b00);
            tag_q.push_back(tag);
        end
    endtask

    task automatic write_reg(input logic [7:0] val);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
        check(rd_data === val, "R2 readback", int'(rd_data), int'(val));
    endtask

    // Monitor: one expected item per clock, sampled a quarter period after the edge
    initial begin
        forever begin
            logic [1:0] e;
            string      t;
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (drive !== e) begin
                    fails++;
                    $display("FAIL %s drive actual=%b expected=%b", t, drive, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        en      = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        check(drive === 2'b00, "R1 drive in reset", int'(drive), 0);
        check(rd_data === 8'h00, "R1 readback in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(drive === 2'b00, "R1 drive after reset", int'(drive), 0);
        check(rd_data === 8'h00, "R1 readback after reset", int'(rd_data), 0);

        // Duties 1 and 3: slot count, period length, channel independence
        write_reg(8'h31);
        en = 1'b1;
        push_period(1, 3, PERIOD, "R3 R4 R6 period1");
        push_period(1, 3, PERIOD, "R3 R4 R6 period2");
        repeat (2 * PERIOD) @(negedge clk);
        en = 1'b0;
        push_zero(5, "R8 disabled");
        repeat (5) @(negedge clk);

        // Off and full-scale, then a mid-period change
        write_reg(8'hF0);
        en = 1'b1;
        push_period(0, 15, PERIOD, "R4 R5 old duty kept");
        push_period(8, 0, PERIOD, "R7 new duty next period");
        repeat (40) @(negedge clk);
        write_reg(8'h08);
        repeat (2 * PERIOD - 41) @(negedge clk);
        en = 1'b0;
        push_zero(4, "R8 disabled");
        repeat (4) @(negedge clk);

        // Stop at slot 8, restart from slot 0
        write_reg(8'h52);
        en = 1'b1;
        push_period(2, 5, 100, "R9 partial");
        repeat (100) @(negedge clk);
        en = 1'b0;
        push_zero(7, "R8 R9 stopped");
        repeat (7) @(negedge clk);
        en = 1'b1;
        push_period(2, 5, PERIOD, "R9 fresh period");
        repeat (PERIOD) @(negedge clk);
        en = 1'b0;
        push_zero(3, "R8 disabled");
        repeat (3) @(negedge clk);

        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule